// File: doc/BRIEF.md
# Timing Reference Selection Controller

This block decides which clock source drives the node. It watches three ranked timing references and an internal oscillator, and picks the best usable one. Each reference comes with a signal-present flag and a frequency-out-of-range flag. A one-cycle seconds tick drives every timer. A separate loop measures the frequency offset of the candidate against the stored calibration, in parts per billion, and reports it as a number. The block then takes the chosen reference through an acquisition window, an optional fast-start stage with post-qualification, and normal lock. When every reference is lost, it falls back to holdover or free-run.

An operator can force the source to any reference or to the internal clock. Forcing a reference that is not usable is refused. The block reports the selected source, an operating mode, per-reference loss and out-of-range flags, a switched-to indication for automatic moves, and one-hot manual-switch conditions.

The named states are FREE (free-run on the internal clock), ACQ (acquisition window), FAST (fast-start pull-in), PQUAL (post-qualification window), LOCK (normal tracking) and HOLD (holdover). The transitions are:
- FREE to ACQ, and HOLD to ACQ, when a reference becomes eligible.
- ACQ to FAST or to LOCK at the end of the acquisition window.
- FAST to PQUAL on the sync indication.
- PQUAL to LOCK or back to FAST at the end of its window.
- Any state to ACQ when the source changes to a reference.
- Any state to HOLD or FREE when the source changes to internal.
- HOLD to FREE when the stored holdover value is flagged corrupt.

Top module: `timing_ref_selector`

## Requirements
- R1: References rank 0 (highest), 1, 2. When the active reference becomes unusable, `src_sel` moves on the next clock edge to the highest-ranked usable reference. Encodings: `src_sel` 0/1/2 = reference, 3 = internal.
- R2: On an automatic move to reference k, `sw_cond` becomes one-hot with bit k set, on the same edge that `src_sel` changes. `loss_alm[i]` is the registered inverse of `ref_ok[i]`, so the loss flag for a dropped reference rises on that same edge.
- R3: When the source changes to internal with no manual command, the mode becomes holdover (5) if the previous reference was in LOCK for more than HOLD_MIN_SECS ticks. Otherwise it becomes free-run (0). Exactly HOLD_MIN_SECS ticks gives free-run.
- R4: Holdover persists for any number of ticks while no reference is eligible. If `hold_bad` is high in holdover, the mode becomes free-run on the next edge.
- R5: After a switch to a reference, the mode is acquisition (1) for QUAL_SECS ticks. At the last tick it becomes fast-start (2) if `meas_offset` > OFFSET_LIMIT_PPB, else locked (4). An offset equal to the limit locks. `fast_cond` is high in modes 2 and 3.
- R6: In fast-start, `fs_synced` moves to post-qualification (3) for QUAL_SECS ticks. At the last tick, `pq_pass` high gives locked; low returns to fast-start.
- R7: A `man_req` with `man_sel` 0/1/2/3 (reference 0/1/2, internal 3) sets `man_cond` one-hot at bit `man_sel` on the next edge. `src_sel` follows on the edge after, and `sw_cond` clears. Forced internal gives mode free-run. `man_clr` returns to automatic selection.
- R8: A reference with `ref_oob` high is not usable. It is left on the next edge under automatic selection. `oob_cond[i]` is the registered value of `ref_ok[i] & ref_oob[i]`.
- R9: A `man_req` naming a reference that is not usable is ignored: `man_cond` and `src_sel` are unchanged.
- R10: From internal, or from a lower-ranked reference, the block moves to a reference only after that reference has been usable for QUAL_SECS consecutive ticks.
- R11: After reset: `src_sel`=3, mode free-run, `sw_cond`=0, `man_cond`=0, `hold_alm`=0, `free_cond`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle seconds tick |
| ref_ok | input | 3 | Signal present, per reference |
| ref_oob | input | 3 | Frequency out of range, per reference |
| meas_offset | input | OFF_W | Offset magnitude of the candidate, in ppb |
| fs_synced | input | 1 | Fast-start pull-in reached sync |
| pq_pass | input | 1 | Post-qualification data agrees |
| hold_bad | input | 1 | Stored holdover value is corrupt |
| man_req | input | 1 | Manual switch request pulse |
| man_sel | input | 2 | Manual target: 0..2 reference, 3 internal |
| man_clr | input | 1 | Return to automatic selection |
| src_sel | output | 2 | Selected source, 3 = internal |
| mode | output | 3 | 0 free, 1 acquire, 2 fast, 3 post-qual, 4 locked, 5 holdover |
| loss_alm | output | 3 | Loss of signal per reference |
| oob_cond | output | 3 | Out-of-range per reference |
| sw_cond | output | 3 | Automatic switch target, one-hot |
| man_cond | output | 4 | Manual switch target, one-hot |
| fast_cond | output | 1 | Fast-start in progress |
| hold_alm | output | 1 | Holdover |
| free_cond | output | 1 | Free-run |

## Verification
The hardest state to reach is the holdover-versus-free-run split. It requires an uninterrupted lock longer than the tracking threshold, followed by loss of every reference in one cycle. The bench holds the tick high for whole windows, so qualification, acquisition and the lock count run at one second per cycle. It then drops all references after exactly the threshold and after one tick more, and compares the two outcomes. The fast-start loop is reached the same way: an offset above the limit, a sync pulse, then a failing and a passing post-qualification window.

// File: rtl/tref_pkg.sv
package tref_pkg;
    localparam int NREF = 3;
    localparam logic [1:0] SRC_INT = 2'd3;

    typedef enum logic [2:0] {
        ST_FREE  = 3'd0,
        ST_ACQ   = 3'd1,
        ST_FAST  = 3'd2,
        ST_PQUAL = 3'd3,
        ST_LOCK  = 3'd4,
        ST_HOLD  = 3'd5
    } sel_state_e;
endpackage

// File: rtl/tref_qualifier.sv
// Counts consecutive ticks during which one reference stays usable.
module tref_qualifier #(
    parameter int QUAL_SECS = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic usable,
    output logic qualified
);
    localparam int CW = $clog2(QUAL_SECS + 1);
    localparam logic [CW-1:0] CMAX = CW'(QUAL_SECS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!usable)
            cnt <= '0;
        else if (sec_tick && cnt != CMAX)
            cnt <= cnt + 1'b1;
    end

    assign qualified = (cnt == CMAX);
endmodule

// File: rtl/tref_picker.sv
// Chooses the target source: manual override, else highest-ranked eligible.
module tref_picker
    import tref_pkg::*;
(
    input  logic [NREF-1:0] elig,
    input  logic            man_on,
    input  logic [1:0]      man_src,
    output logic [1:0]      tgt
);
    always_comb begin
        tgt = SRC_INT;
        if (man_on) begin
            tgt = man_src;
        end else begin
            for (int i = NREF - 1; i >= 0; i--)
                if (elig[i]) tgt = 2'(i);
        end
    end
endmodule

// File: rtl/timing_ref_selector.sv
module timing_ref_selector
    import tref_pkg::*;
#(
    parameter int QUAL_SECS        = 30,
    parameter int HOLD_MIN_SECS    = 140,
    parameter int OFF_W            = 16,
    parameter int OFFSET_LIMIT_PPB = 4000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic [2:0]       ref_ok,
    input  logic [2:0]       ref_oob,
    input  logic [OFF_W-1:0] meas_offset,
    input  logic             fs_synced,
    input  logic             pq_pass,
    input  logic             hold_bad,
    input  logic             man_req,
    input  logic [1:0]       man_sel,
    input  logic             man_clr,
    output logic [1:0]       src_sel,
    output logic [2:0]       mode,
    output logic [2:0]       loss_alm,
    output logic [2:0]       oob_cond,
    output logic [2:0]       sw_cond,
    output logic [3:0]       man_cond,
    output logic             fast_cond,
    output logic             hold_alm,
    output logic             free_cond
);
    localparam int WIN_W = $clog2(QUAL_SECS + 1);
    localparam int TRK_W = $clog2(HOLD_MIN_SECS + 2);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(QUAL_SECS - 1);
    localparam logic [TRK_W-1:0] TRK_LIM  = TRK_W'(HOLD_MIN_SECS);
    localparam logic [OFF_W-1:0] OFF_LIM  = OFF_W'(OFFSET_LIMIT_PPB);

    sel_state_e       state, nxt_state;
    logic [1:0]       src_q, tgt, man_src;
    logic             man_on, switching, win_clr, win_inc, win_end;
    logic [WIN_W-1:0] win_cnt;
    logic [TRK_W-1:0] trk_cnt;
    logic [NREF-1:0]  usable, qual, elig;
    logic [3:0]       usable4;

    assign usable  = ref_ok & ~ref_oob;
    assign usable4 = {1'b1, usable};

    for (genvar g = 0; g < NREF; g++) begin : g_ref
        tref_qualifier #(.QUAL_SECS(QUAL_SECS)) u_qual (
            .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
            .usable(usable[g]), .qualified(qual[g])
        );
        // Current or lower-ranked references need no fresh qualification.
        assign elig[g] = usable[g] &
                         (qual[g] | ((src_q != SRC_INT) && (2'(g) >= src_q)));
    end

    tref_picker u_pick (
        .elig(elig), .man_on(man_on), .man_src(man_src), .tgt(tgt)
    );

    assign switching = (tgt != src_q);
    assign win_end   = (win_cnt == WIN_LAST);

    // Next-state logic
    always_comb begin
        nxt_state = state;
        win_clr   = 1'b0;
        win_inc   = 1'b0;
        if (switching) begin
            win_clr = 1'b1;
            if (tgt != SRC_INT)
                nxt_state = ST_ACQ;
            else if (!man_on && trk_cnt > TRK_LIM && !hold_bad)
                nxt_state = ST_HOLD;
            else
                nxt_state = ST_FREE;
        end else begin
            unique case (state)
                ST_ACQ: if (sec_tick) begin
                    if (win_end) begin
                        win_clr   = 1'b1;
                        nxt_state = (meas_offset > OFF_LIM) ? ST_FAST : ST_LOCK;
                    end else begin
                        win_inc = 1'b1;
                    end
                end
                ST_FAST: if (fs_synced) begin
                    win_clr   = 1'b1;
                    nxt_state = ST_PQUAL;
                end
                ST_PQUAL: if (sec_tick) begin
                    if (win_end) begin
                        win_clr   = 1'b1;
                        nxt_state = pq_pass ? ST_LOCK : ST_FAST;
                    end else begin
                        win_inc = 1'b1;
                    end
                end
                ST_HOLD: if (hold_bad) nxt_state = ST_FREE;
                default: ;
            endcase
        end
    end

    // State register, timers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_FREE;
            src_q   <= SRC_INT;
            win_cnt <= '0;
            trk_cnt <= '0;
        end else begin
            state <= nxt_state;
            src_q <= tgt;
            if (win_clr)      win_cnt <= '0;
            else if (win_inc) win_cnt <= win_cnt + 1'b1;
            if (switching || state != ST_LOCK)
                trk_cnt <= '0;
            else if (sec_tick && trk_cnt <= TRK_LIM)
                trk_cnt <= trk_cnt + 1'b1;
        end
    end

    // Manual override register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            man_on  <= 1'b0;
            man_src <= SRC_INT;
        end else if (man_clr) begin
            man_on <= 1'b0;
        end else if (man_req && usable4[man_sel]) begin
            man_on  <= 1'b1;
            man_src <= man_sel;
        end else if (man_on && !usable4[man_src]) begin
            man_on <= 1'b0;
        end
    end

    // Registered condition outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loss_alm <= '0;
            oob_cond <= '0;
            sw_cond  <= '0;
        end else begin
            loss_alm <= ~ref_ok;
            oob_cond <= ref_ok & ref_oob;
            if (switching)
                sw_cond <= (!man_on && tgt != SRC_INT) ? 3'(3'b001 << tgt) : 3'b000;
        end
    end

    assign src_sel   = src_q;
    assign mode      = state;
    assign man_cond  = man_on ? 4'(4'b0001 << man_src) : 4'b0000;
    assign fast_cond = (state == ST_FAST) || (state == ST_PQUAL);
    assign hold_alm  = (state == ST_HOLD);
    assign free_cond = (state == ST_FREE);
endmodule

// File: rtl/tref_sel_chk.sv
module tref_sel_chk
    import tref_pkg::*;
#(
    parameter int HOLD_MIN_SECS    = 140,
    parameter int OFF_W            = 16,
    parameter int OFFSET_LIMIT_PPB = 4000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sec_tick,
    input logic [2:0]       ref_ok,
    input logic [2:0]       ref_oob,
    input logic [OFF_W-1:0] meas_offset,
    input logic             pq_pass,
    input logic             hold_bad,
    input logic             man_req,
    input logic [1:0]       man_sel,
    input logic             man_clr,
    input logic [1:0]       src_sel,
    input logic [2:0]       mode,
    input logic [1:0]       loss_alm,
    input logic [2:0]       sw_cond,
    input logic [3:0]       man_cond,
    input logic             hold_alm,
    input logic             free_cond
);
    localparam int LW = $clog2(HOLD_MIN_SECS + 2);
    localparam logic [LW-1:0] LLIM = LW'(HOLD_MIN_SECS);
    localparam logic [OFF_W-1:0] OLIM = OFF_W'(OFFSET_LIMIT_PPB);

    // Independent count of ticks spent in locked mode.
    logic [LW-1:0] lock_secs;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         lock_secs <= '0;
        else if (mode != ST_LOCK)           lock_secs <= '0;
        else if (sec_tick && lock_secs <= LLIM) lock_secs <= lock_secs + 1'b1;
    end

    for (genvar i = 0; i < 2; i++) begin : g_fail
        // R2
        failover_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (src_sel == 2'(i) && man_cond == 4'b0 && !ref_ok[0] && !ref_ok[i] &&
             ref_ok[i+1] && !ref_oob[i+1])
            |=> (src_sel == 2'(i + 1) && loss_alm[i] && sw_cond == 3'(1 << (i + 1))));
    end

    for (genvar i = 0; i < 3; i++) begin : g_ref
        // R8
        oob_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (src_sel == 2'(i) && man_cond == 4'b0 && ref_oob[i]) |=> (src_sel != 2'(i)));
        // R9
        man_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (man_req && !man_clr && man_sel == 2'(i) && man_cond == 4'b0 &&
             !(ref_ok[i] && !ref_oob[i])) |=> (man_cond == 4'b0));
    end

    // R3
    hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_alm) |-> ($past(lock_secs) > LLIM));

    // R4
    hold_corrupt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_alm && hold_bad) |=> !hold_alm);

    // R4
    hold_internal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_alm |-> (src_sel == SRC_INT));

    // R5
    fast_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_FAST && $past(mode) == ST_ACQ) |-> ($past(meas_offset) > OLIM));

    // R6
    pq_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_LOCK && $past(mode) == ST_PQUAL) |-> $past(pq_pass));

    // R7
    man_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (man_cond == 4'b1000 && src_sel != SRC_INT) |=> (src_sel == SRC_INT && free_cond));
endmodule

bind timing_ref_selector tref_sel_chk #(
    .HOLD_MIN_SECS(HOLD_MIN_SECS), .OFF_W(OFF_W), .OFFSET_LIMIT_PPB(OFFSET_LIMIT_PPB)
) i_chk (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .ref_ok(ref_ok), .ref_oob(ref_oob),
    .meas_offset(meas_offset), .pq_pass(pq_pass), .hold_bad(hold_bad),
    .man_req(man_req), .man_sel(man_sel), .man_clr(man_clr), .src_sel(src_sel),
    .mode(mode), .loss_alm(loss_alm[1:0]), .sw_cond(sw_cond), .man_cond(man_cond),
    .hold_alm(hold_alm), .free_cond(free_cond)
);

// File: tb/test_timing_ref_selector.sv
module test_timing_ref_selector;
    localparam int QS = 30;
    localparam int HM = 140;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic [2:0]  ref_ok = 3'b000;
    logic [2:0]  ref_oob = 3'b000;
    logic [15:0] meas_offset = 16'd0;
    logic        fs_synced = 1'b0;
    logic        pq_pass = 1'b0;
    logic        hold_bad = 1'b0;
    logic        man_req = 1'b0;
    logic [1:0]  man_sel = 2'd0;
    logic        man_clr = 1'b0;
    logic [1:0]  src_sel;
    logic [2:0]  mode, loss_alm, oob_cond, sw_cond;
    logic [3:0]  man_cond;
    logic        fast_cond, hold_alm, free_cond;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    timing_ref_selector i_timing_ref_selector (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .ref_ok(ref_ok), .ref_oob(ref_oob),
        .meas_offset(meas_offset), .fs_synced(fs_synced), .pq_pass(pq_pass),
        .hold_bad(hold_bad), .man_req(man_req), .man_sel(man_sel), .man_clr(man_clr),
        .src_sel(src_sel), .mode(mode), .loss_alm(loss_alm), .oob_cond(oob_cond),
        .sw_cond(sw_cond), .man_cond(man_cond), .fast_cond(fast_cond),
        .hold_alm(hold_alm), .free_cond(free_cond)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        sec_tick = 1'b1;
        step(n);
        sec_tick = 1'b0;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic man_pulse(input logic [1:0] sel);
        man_sel = sel; man_req = 1'b1;
        step(1);
        man_req = 1'b0;
        step(1);
    endtask

    task automatic t_reset;
        step(3);
        rst_n = 1'b1;
        step(1);
        check("R11", "src_sel", int'(src_sel), 3);
        check("R11", "mode", int'(mode), 0);
        check("R11", "sw_cond", int'(sw_cond), 0);
        check("R11", "man_cond", int'(man_cond), 0);
        check("R11", "hold_alm", int'(hold_alm), 0);
        check("R11", "free_cond", int'(free_cond), 1);
    endtask

    // First qualification, acquisition with offset exactly at the limit.
    task automatic t_first_lock;
        ref_ok = 3'b111; meas_offset = 16'd4000;
        ticks(QS - 1);
        step(1);
        check("R10", "src before window full", int'(src_sel), 3);
        ticks(1);
        step(1);
        check("R1", "src after qualification", int'(src_sel), 0);
        check("R5", "mode acquire", int'(mode), 1);
        ticks(QS - 1);
        check("R5", "mode before window end", int'(mode), 1);
        ticks(1);
        check("R5", "mode lock at limit", int'(mode), 4);
        check("R5", "fast_cond", int'(fast_cond), 0);
    endtask

    task automatic t_failover_and_return;
        ref_ok[0] = 1'b0;
        step(1);
        check("R1", "src after primary loss", int'(src_sel), 1);
        check("R2", "loss_alm", int'(loss_alm), 1);
        check("R2", "sw_cond", int'(sw_cond), 2);
        ref_ok[0] = 1'b1;
        ticks(QS - 1);
        check("R10", "no early return", int'(src_sel), 1);
        ticks(1);
        step(1);
        check("R10", "return to primary", int'(src_sel), 0);
        check("R2", "loss_alm cleared", int'(loss_alm), 0);
    endtask

    task automatic t_short_lock_free;
        ref_ok = 3'b000;
        step(1);
        check("R3", "src internal", int'(src_sel), 3);
        check("R3", "free after short track", int'(mode), 0);
        check("R3", "hold_alm", int'(hold_alm), 0);
    endtask

    task automatic lock_for(input int secs);
        ref_ok = 3'b111;
        ticks(QS);
        step(1);
        ticks(QS);
        ticks(secs);
        ref_ok = 3'b000;
        step(1);
    endtask

    task automatic t_holdover;
        lock_for(HM);
        check("R3", "free at exact threshold", int'(mode), 0);
        lock_for(HM + 1);
        check("R3", "holdover past threshold", int'(mode), 5);
        check("R3", "hold_alm", int'(hold_alm), 1);
        ticks(5);
        check("R4", "holdover persists", int'(mode), 5);
        hold_bad = 1'b1;
        step(1);
        hold_bad = 1'b0;
        check("R4", "corrupt holdover to free", int'(mode), 0);
    endtask

    task automatic t_fast_start;
        ref_ok = 3'b111; meas_offset = 16'd5000;
        ticks(QS);
        step(1);
        ticks(QS);
        check("R5", "fast-start entry", int'(mode), 2);
        check("R5", "fast_cond", int'(fast_cond), 1);
        fs_synced = 1'b1; step(1); fs_synced = 1'b0;
        check("R6", "post-qual", int'(mode), 3);
        pq_pass = 1'b0;
        ticks(QS);
        check("R6", "post-qual fail loops", int'(mode), 2);
        fs_synced = 1'b1; step(1); fs_synced = 1'b0;
        pq_pass = 1'b1;
        ticks(QS);
        pq_pass = 1'b0;
        check("R6", "post-qual pass locks", int'(mode), 4);
        check("R6", "fast_cond cleared", int'(fast_cond), 0);
    endtask

    task automatic t_second_to_third;
        ref_ok[0] = 1'b0;
        step(1);
        ref_ok[1] = 1'b0;
        step(1);
        check("R2", "src third", int'(src_sel), 2);
        check("R2", "sw_cond third", int'(sw_cond), 4);
        check("R2", "loss_alm", int'(loss_alm), 3);
    endtask

    task automatic t_out_of_bounds;
        ref_oob[2] = 1'b1;
        step(1);
        check("R8", "oob ref dropped", int'(src_sel), 3);
        check("R8", "oob_cond", int'(oob_cond), 4);
        check("R8", "loss_alm unaffected", int'(loss_alm[2]), 0);
        ref_oob = 3'b000;
    endtask

    task automatic t_manual;
        ref_ok = 3'b111;
        ticks(QS);
        step(1);
        check("R1", "auto primary", int'(src_sel), 0);
        man_pulse(2'd2);
        check("R7", "forced third", int'(src_sel), 2);
        check("R7", "man_cond third", int'(man_cond), 4);
        check("R7", "sw_cond cleared", int'(sw_cond), 0);
        man_pulse(2'd3);
        check("R7", "forced internal", int'(src_sel), 3);
        check("R7", "free mode", int'(mode), 0);
        check("R7", "man_cond internal", int'(man_cond), 8);
        ref_ok[1] = 1'b0;
        man_pulse(2'd1);
        step(1);
        check("R9", "reject keeps cond", int'(man_cond), 8);
        check("R9", "reject keeps src", int'(src_sel), 3);
        man_clr = 1'b1; step(1); man_clr = 1'b0;
        step(1);
        check("R7", "auto resumes", int'(src_sel), 0);
        check("R7", "man_cond off", int'(man_cond), 0);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_first_lock();
        t_failover_and_return();
        t_short_lock_free();
        t_holdover();
        t_fast_start();
        t_second_to_third();
        t_out_of_bounds();
        t_manual();
        finish_run();
    end
endmodule